// File: doc/BRIEF.md
# Instruction Bundle Issue Splitter

This block sits between instruction fetch and the execution lanes of a wide-issue core. Fetch delivers fixed 128-bit packets. Each packet carries three 41-bit instruction slots and a 5-bit scheduling template. Stop bits in the template mark where a parallel group ends. A group needs no stop inside a packet, so it can run on through any number of packets. The compiler guarantees that the instructions inside one group do not depend on each other. For that reason the block never checks dependencies. It only decides how many of the buffered slots go out together in each cycle.

The block holds one packet. Each cycle it presents a chunk of up to `ISSUE_W` consecutive slots, oldest first. A chunk stops at the first set stop bit or at the end of the packet, whichever comes first. A group wider than the lanes is therefore issued as several chunks in program order.

The execution side reports, per lane, whether a branch in that lane was taken. The first taken lane closes the group. The block then squashes the lanes above it, discards the rest of the buffered packet, and waits for the redirected packet stream. The packet input accepts a new packet only when the current chunk empties the buffer.

Top module: `bundle_issue_splitter`

## Requirements
- R1: After reset, no issue lane is valid, `grp_end` is low and `pkt_ready` is high.
- R2: Slot 0 is taken from packet bits [45:5], slot 1 from [86:46] and slot 2 from [127:87]. Issue lane k carries its word on `iss_word[k*41 +: 41]`.
- R3: A packet accepted in cycle t (`pkt_valid` and `pkt_ready` both high) presents its first chunk in cycle t+1, and that chunk has lane 0 valid.
- R4: Template bit i (bits [2:0]) is the stop bit after slot i. A chunk never extends past a slot whose stop bit is set, and `grp_end` is high exactly on the chunk that ends at such a slot or at a taken branch.
- R5: The valid lanes of a chunk are contiguous from lane 0. Their number is the smaller of `ISSUE_W` and the count of buffered slots up to and including the first stop slot or slot 2.
- R6: When a packet has no stop bit set from the current slot onward, the group continues into the next packet and `grp_end` stays low.
- R7: `pkt_ready` is low while buffered slots remain after the current chunk. It is high when the buffer is empty or when the current chunk drains it.
- R8: When lane k is valid and its `br_taken` bit is high, and no lower valid lane is taken, lanes above k are not valid and `grp_end` is high. The remaining buffered slots are discarded, so no lane is valid until a new packet is accepted.
- R9: A `br_taken` bit on a lane that is not valid in that cycle has no effect on the issue stream.
- R10: Template bits [4:3] have no effect on the issue stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pkt_valid | input | 1 | Packet offered |
| pkt_ready | output | 1 | Packet can be accepted this cycle |
| pkt_data | input | 128 | Packet: template [4:0], slots above it |
| br_taken | input | ISSUE_W | Per-lane taken-branch resolution for the current chunk |
| iss_valid | output | ISSUE_W | Per-lane issue valid, lane 0 oldest |
| iss_word | output | ISSUE_W*41 | Per-lane instruction word |
| grp_end | output | 1 | Current chunk closes its group |

## Verification
A wrong slot pointer shows in the very next chunk. The lane words then come from the wrong slot positions, or a stop bit is skipped, so `grp_end` appears on the wrong chunk. A buffer-valid flag stuck high or low appears within one cycle as either a stalled `pkt_ready` or a missing chunk one cycle after a packet is accepted. A bad flush on a taken branch shows up as stale slots issued in the following cycle. The bench compares every lane, word, `grp_end` and `pkt_ready` in every cycle, so each of these faults is reported in the cycle where it first appears.

// File: rtl/bsp_pkg.sv
`timescale 1ns/1ps
package bsp_pkg;
  localparam int SLOT_W = 41;
  localparam int SLOTS  = 3;
  localparam int TMPL_W = 5;
  localparam int PKT_W  = SLOTS * SLOT_W + TMPL_W;

  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [1:0]        sidx_t;
endpackage

// File: rtl/bsp_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assert, synchronous release of the active-low reset.
module bsp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_q_n = sh_q[1];
endmodule

// File: rtl/bsp_hold.sv
`timescale 1ns/1ps
// One-packet holding stage: slot words, stop bits, read pointer.
module bsp_hold
  import bsp_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic                          drop,
  input  logic                          adv,
  input  logic [1:0]                    adv_cnt,
  input  logic [PKT_W-1:0]              pkt,
  output logic                          hold_vld,
  output logic [SLOTS-1:0][SLOT_W-1:0]  slot_q,
  output logic [SLOTS-1:0]              stop_q,
  output sidx_t                         ptr_q
);
  logic  vld_d;
  sidx_t ptr_d;

  always_comb begin
    vld_d = hold_vld;
    ptr_d = ptr_q;
    if (load) begin
      vld_d = 1'b1;
      ptr_d = '0;
    end else if (drop) begin
      vld_d = 1'b0;
    end else if (adv) begin
      ptr_d = ptr_q + adv_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld <= 1'b0;
      ptr_q    <= '0;
    end else begin
      hold_vld <= vld_d;
      ptr_q    <= ptr_d;
    end
  end

  // Data registers: enable only, no reset (gated by hold_vld downstream).
  always_ff @(posedge clk) begin
    if (load) begin
      stop_q <= pkt[SLOTS-1:0];
      for (int s = 0; s < SLOTS; s++)
        slot_q[s] <= pkt[TMPL_W + s*SLOT_W +: SLOT_W];
    end
  end
endmodule

// File: rtl/bsp_pick.sv
`timescale 1ns/1ps
// Chunk selection: lanes from the pointer up to a stop, packet end,
// lane count or the first taken branch.
module bsp_pick
  import bsp_pkg::*;
#(
  parameter int ISSUE_W = 3
) (
  input  logic                           hold_vld,
  input  logic [SLOTS-1:0][SLOT_W-1:0]   slot_q,
  input  logic [SLOTS-1:0]               stop_q,
  input  sidx_t                          ptr_q,
  input  logic [ISSUE_W-1:0]             br_taken,
  output logic [ISSUE_W-1:0]             lane_vld,
  output logic [ISSUE_W-1:0][SLOT_W-1:0] lane_word,
  output logic                           grp_end,
  output logic [1:0]                     used,
  output logic                           done
);
  logic       open;
  logic       flush;
  logic [2:0] idx;

  always_comb begin
    lane_vld  = '0;
    lane_word = '0;
    grp_end   = 1'b0;
    flush     = 1'b0;
    used      = '0;
    open      = hold_vld;
    idx       = '0;
    for (int k = 0; k < ISSUE_W; k++) begin
      idx = {1'b0, ptr_q} + 3'(k);
      if (open && idx < 3'(SLOTS)) begin
        lane_vld[k]  = 1'b1;
        lane_word[k] = slot_q[idx[1:0]];
        used         = used + 2'd1;
        if (br_taken[k]) begin
          flush   = 1'b1;
          grp_end = 1'b1;
          open    = 1'b0;
        end
        if (stop_q[idx[1:0]]) begin
          grp_end = 1'b1;
          open    = 1'b0;
        end
      end else begin
        open = 1'b0;
      end
    end
    done = hold_vld && (flush || (({1'b0, ptr_q} + {1'b0, used}) == 3'(SLOTS)));
  end
endmodule

// File: rtl/bundle_issue_splitter.sv
`timescale 1ns/1ps
module bundle_issue_splitter
  import bsp_pkg::*;
#(
  parameter int ISSUE_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pkt_valid,
  output logic                      pkt_ready,
  input  logic [PKT_W-1:0]          pkt_data,
  input  logic [ISSUE_W-1:0]        br_taken,
  output logic [ISSUE_W-1:0]        iss_valid,
  output logic [ISSUE_W*SLOT_W-1:0] iss_word,
  output logic                      grp_end
);
  logic                           rst_q_n;
  logic                           hold_vld;
  logic [SLOTS-1:0][SLOT_W-1:0]   slot_q;
  logic [SLOTS-1:0]               stop_q;
  sidx_t                          ptr_q;
  logic [ISSUE_W-1:0][SLOT_W-1:0] lane_word;
  logic [1:0]                     used;
  logic                           done;
  logic                           load;

  bsp_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  assign pkt_ready = !hold_vld || done;
  assign load      = pkt_valid && pkt_ready;

  bsp_hold u_hold (
    .clk(clk), .rst_n(rst_q_n), .load(load), .drop(done),
    .adv(hold_vld), .adv_cnt(used), .pkt(pkt_data),
    .hold_vld(hold_vld), .slot_q(slot_q), .stop_q(stop_q), .ptr_q(ptr_q)
  );

  bsp_pick #(.ISSUE_W(ISSUE_W)) u_pick (
    .hold_vld(hold_vld), .slot_q(slot_q), .stop_q(stop_q), .ptr_q(ptr_q),
    .br_taken(br_taken), .lane_vld(iss_valid), .lane_word(lane_word),
    .grp_end(grp_end), .used(used), .done(done)
  );

  assign iss_word = lane_word;
endmodule

// File: rtl/bsp_checker.sv
`timescale 1ns/1ps
module bsp_checker #(
  parameter int ISSUE_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pkt_valid,
  input logic               pkt_ready,
  input logic [ISSUE_W-1:0] br_taken,
  input logic [ISSUE_W-1:0] iss_valid,
  input logic               grp_end
);
  AST_ACCEPT_ISSUES: assert property (@(posedge clk) disable iff (!rst_n) (pkt_valid && pkt_ready) |=> iss_valid[0]); // R3
  AST_END_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n) grp_end |-> iss_valid[0]); // R4
  AST_LANES_CONTIG: assert property (@(posedge clk) disable iff (!rst_n) ((iss_valid & (iss_valid + 1'b1)) == '0)); // R5
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n) (iss_valid == '0) |-> pkt_ready); // R7
  AST_TAKEN_ENDS: assert property (@(posedge clk) disable iff (!rst_n) ((iss_valid & br_taken) != '0) |-> grp_end); // R8
  AST_ONE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) $countones(iss_valid & br_taken) <= 1); // R8
endmodule

bind bundle_issue_splitter bsp_checker #(.ISSUE_W(ISSUE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
  .br_taken(br_taken), .iss_valid(iss_valid), .grp_end(grp_end)
);

// File: tb/sim_bundle_issue_splitter.sv
`timescale 1ns/1ps
module sim_bundle_issue_splitter;
  localparam int W  = 2;
  localparam int SW = 41;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            pkt_valid;
  logic            pkt_ready;
  logic [127:0]    pkt_data;
  logic [W-1:0]    br_taken;
  logic [W-1:0]    iss_valid;
  logic [W*SW-1:0] iss_word;
  logic            grp_end;

  int    n_run  = 0;
  int    n_fail = 0;
  string ctx    = "R1";
  bit    last_acc;
  bit    finished = 0;

  // Reference model state
  bit          m_vld = 0;
  logic [SW-1:0] m_slot [3];
  bit [2:0]    m_stop;
  int          m_ptr = 0;

  always #2.5 clk = ~clk;

  bundle_issue_splitter #(.ISSUE_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_data(pkt_data), .br_taken(br_taken), .iss_valid(iss_valid),
    .iss_word(iss_word), .grp_end(grp_end)
  );

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s [%s] act=%h exp=%h", req, what, ctx, act, exp);
    end
  endtask

  function automatic logic [127:0] mk(logic [SW-1:0] a, logic [SW-1:0] b,
                                      logic [SW-1:0] c, logic [2:0] st, logic [1:0] hi);
    return {c, b, a, hi, st};
  endfunction

  function automatic logic [SW-1:0] rw();
    return {$urandom(), $urandom()};
  endfunction

  task automatic step(bit v, logic [127:0] d, logic [W-1:0] br);
    int n; bit fl, ge, rdy; logic [W-1:0] ev;
    @(negedge clk);
    pkt_valid = v; pkt_data = d; br_taken = br;
    #1;
    n = 0; fl = 0; ge = 0; ev = '0;
    if (m_vld) begin
      for (int k = 0; k < W; k++) begin
        if (m_ptr + k > 2) break;
        ev[k] = 1'b1; n++;
        chk(iss_word[k*SW +: SW] == m_slot[m_ptr+k], "R2", "word",
            64'(iss_word[k*SW +: SW]), 64'(m_slot[m_ptr+k]));
        if (br[k]) begin fl = 1; ge = 1; break; end
        if (m_stop[m_ptr+k]) begin ge = 1; break; end
      end
    end
    rdy = !m_vld || fl || (m_ptr + n == 3);
    chk(iss_valid == ev, "R5", "lanes", 64'(iss_valid), 64'(ev));
    chk(grp_end == ge, "R4", "grp_end", 64'(grp_end), 64'(ge));
    chk(pkt_ready == rdy, "R7", "ready", 64'(pkt_ready), 64'(rdy));
    last_acc = v && rdy;
    if (last_acc) begin
      m_vld = 1; m_ptr = 0; m_stop = d[2:0];
      for (int s = 0; s < 3; s++) m_slot[s] = d[5 + s*SW +: SW];
    end else if (m_vld) begin
      if (fl || (m_ptr + n == 3)) m_vld = 0;
      else m_ptr += n;
    end
  endtask

  task automatic send(logic [127:0] d);
    do step(1'b1, d, '0); while (!last_acc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; pkt_valid = 1'b0; pkt_data = '0; br_taken = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(iss_valid == '0, "R1", "reset lanes", 64'(iss_valid), 0);
    chk(grp_end == 1'b0, "R1", "reset grp_end", 64'(grp_end), 0);
    chk(pkt_ready == 1'b1, "R1", "reset ready", 64'(pkt_ready), 1);
    rst_n = 1'b1;
    repeat (4) step(0, '0, '0);

    ctx = "R3";   // first chunk one cycle after accept
    send(mk(rw(), rw(), rw(), 3'b111, 2'b00));
    repeat (4) step(0, '0, '0);

    ctx = "R6";   // group spans two packets
    send(mk(rw(), rw(), rw(), 3'b000, 2'b00));
    send(mk(rw(), rw(), rw(), 3'b100, 2'b00));
    repeat (4) step(0, '0, '0);

    ctx = "R10";  // upper template bits set then clear
    send(mk(rw(), rw(), rw(), 3'b010, 2'b11));
    send(mk(rw(), rw(), rw(), 3'b010, 2'b00));
    repeat (4) step(0, '0, '0);

    ctx = "R8";   // taken branch on lane 0 squashes lane 1 and slot 2
    send(mk(rw(), rw(), rw(), 3'b000, 2'b00));
    step(0, '0, 2'b01);
    step(0, '0, '0);
    step(0, '0, '0);
    send(mk(rw(), rw(), rw(), 3'b100, 2'b00));
    step(0, '0, 2'b10);   // taken on lane 1 of first chunk
    repeat (3) step(0, '0, '0);

    ctx = "R9";   // taken bit on a lane not issued (stop at slot 0)
    send(mk(rw(), rw(), rw(), 3'b001, 2'b00));
    step(0, '0, 2'b10);
    repeat (3) step(0, '0, '0);

    ctx = "R5";   // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] br;
      br = ($urandom() % 8 == 0) ? W'($urandom()) : '0;
      step(($urandom() % 4) != 0,
           mk(rw(), rw(), rw(), 3'($urandom()), 2'($urandom())), br);
    end
    repeat (6) step(0, '0, '0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule